// File: doc/BRIEF.md
# Host Mailbox and Boot-Control Register Block

This block is a small 32-bit register file that a host reaches through a simple target bus. The bus has a byte address, separate write and read strobes, and 32-bit write and read data. The block joins that host to one attached processor module through a single word port that can carry data in either direction.

The host places a word in an outbound register. The block passes it to the module once the port turns toward the module. Words sent by the module land in an inbound register, where the host reads them. One full flag guards each register, so neither side overruns the other. When the port is idle it serves whichever side has a word waiting. If both sides are waiting at once, the host side goes first.

A write-only control register drives the module's boot pins:
- a reset line, which is held active from system reset until the host releases it;
- three open-drain flag pins, which can only pull low;
- an active-low non-maskable interrupt line.

The block also has a write-only interrupt-control word and a read-only copy of the last address the host accessed.

Top module: `host_mailbox_ctrl`

## Requirements
- R1: After reset, STATUS reads 0 and `mod_reset` is 1. `mod_nmi_n` is 1, `mod_flag_pull` is 000, `int_ctrl` is 0, and the last-address register reads 0.
- R2: A host write to offset 0x10 while the outbound-full flag is 0 loads the outbound word and sets that flag.
- R3: A host write to offset 0x10 while the outbound-full flag is 1 is dropped. The word later delivered to the module is the earlier one.
- R4: While the outbound flag is set and the port is idle, the port turns toward the module. From the next cycle, `lnk_drive` and `lnk_wvalid` are 1 and `lnk_wdata` holds the word. A cycle with `lnk_wready` high ends the transfer, and the flag is 0 in the following cycle.
- R5: While `lnk_req` is high, the port is idle and both flags are 0, the port turns toward the block in the next cycle, with `lnk_drive` at 0 and `lnk_rready` at 1. A cycle with `lnk_rvalid` high stores `lnk_rdata` in the inbound word and sets the inbound-full flag.
- R6: While the inbound-full flag is 1, `lnk_rready` stays 0 and the inbound word is kept. A host read of 0x10 returns the inbound word and clears the flag.
- R7: When the port is idle and the outbound flag and `lnk_req` are both set, the transfer toward the module is served first.
- R8: A host write to 0x14 sets the control bits from the write data.
  - Bit 0 drives `mod_reset` (1 means the module is held in reset).
  - Bits 1 to 3 release flag pins 0 to 2 when 1. When a bit is 0, its pin pulls low, so `mod_flag_pull[i]` = NOT bit i+1.
  - Bit 4 drives `mod_nmi_n`.
  - Bits 5 and above are ignored.
- R9: A host read of 0x14 returns STATUS: bit 0 is the outbound-full flag, bit 1 is the inbound-full flag, and all other bits are 0.
- R10: A host write to 0x18 loads all 32 bits onto `int_ctrl`. Reads of 0x18 return 0.
- R11: A read of 0x1C returns, in bits 4:0, the word offset (address bits 6:2) of the previous accepted host access, read or write. Every access updates this value.
- R12: Offsets 0x00 to 0x0F and 0x20 to 0x7F read as 0. Writes to these offsets change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 7 | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the current address, valid in the strobe cycle |
| lnk_drive | output | 1 | 1 while the block drives the shared word port |
| lnk_wdata | output | 32 | Word sent to the module |
| lnk_wvalid | output | 1 | Word toward the module is valid |
| lnk_wready | input | 1 | Module takes the word |
| lnk_req | input | 1 | Module asks to send a word |
| lnk_rdata | input | 32 | Word from the module |
| lnk_rvalid | input | 1 | Word from the module is valid |
| lnk_rready | output | 1 | Block accepts a word from the module |
| mod_reset | output | 1 | Module reset, active high |
| mod_flag_pull | output | 3 | Pull-low enables for the open-drain flag pins |
| mod_nmi_n | output | 1 | Active-low non-maskable interrupt |
| int_ctrl | output | 32 | Interrupt-control word |

## Verification
The hardest case to reach from the ports is a tie at the idle port: the outbound flag is already set and the module request is high in the same cycle. The bench reaches it by writing the outbound word, then raising `lnk_req` in the cycle right after, before the port has turned. A second hard case is a module word that waits while the inbound register is full. The bench holds valid data on the port across several cycles, confirms that it is refused and that the earlier word is kept, and then lets it through after the host read.

// File: rtl/hmb_pkg.sv
// Shared constants and types for the host mailbox block.
// The register slots sit on consecutive word offsets, starting at word 4 (byte 0x10).
package hmb_pkg;
    localparam int SLOT_BASE = 4;
    localparam int SLOT_N    = 4;
    localparam int SLOT_DATA = 0;
    localparam int SLOT_CTRL = 1;
    localparam int SLOT_INTC = 2;
    localparam int SLOT_LAST = 3;

    typedef enum logic [1:0] {
        LNK_IDLE     = 2'd0,
        LNK_TO_MOD   = 2'd1,
        LNK_FROM_MOD = 2'd2
    } lnk_state_t;
endpackage

// File: rtl/hmb_decode.sv
// Address decoder: turns the host byte address into one-hot slot hits and
// write/read selects. Assumes a single word-aligned access per strobe cycle.
module hmb_decode
    import hmb_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [SLOT_N-1:0] hit,
    output logic [SLOT_N-1:0] wsel,
    output logic [SLOT_N-1:0] rsel,
    output logic [ADDR_W-3:0] word_idx
);
    localparam int IDX_W = ADDR_W - 2;

    // extract the word offset from the byte address
    assign word_idx = addr[ADDR_W-1:2];

    genvar i;
    generate
        for (i = 0; i < SLOT_N; i++) begin : g_slot
            // compare against the word offset of this slot
            assign hit[i]  = (word_idx == IDX_W'(SLOT_BASE + i));
            assign wsel[i] = hit[i] & wr;
            assign rsel[i] = hit[i] & rd;
        end
    endgenerate
endmodule

// File: rtl/hmb_link.sv
// Word port arbiter with outbound and inbound mailbox words.
// Assumes the module holds lnk_req until its word is taken. The idle port
// gives the outbound direction priority over a module request.
module hmb_link
    import hmb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rx_word,
    output logic              out_full,
    output logic              in_full,
    output logic              lnk_drive,
    output logic [DATA_W-1:0] lnk_wdata,
    output logic              lnk_wvalid,
    input  logic              lnk_wready,
    input  logic              lnk_req,
    input  logic [DATA_W-1:0] lnk_rdata,
    input  logic              lnk_rvalid,
    output logic              lnk_rready
);
    lnk_state_t        state;
    lnk_state_t        state_nx;
    logic [DATA_W-1:0] tx_word;

    // next direction of the shared port
    always_comb begin
        state_nx = state;
        case (state)
            LNK_IDLE: begin
                if (out_full)                  state_nx = LNK_TO_MOD;
                else if (lnk_req && !in_full)  state_nx = LNK_FROM_MOD;
            end
            LNK_TO_MOD:   if (lnk_wready)                state_nx = LNK_IDLE;
            LNK_FROM_MOD: if (lnk_rvalid || !lnk_req)    state_nx = LNK_IDLE;
            default:                                     state_nx = LNK_IDLE;
        endcase
    end

    // port direction register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LNK_IDLE;
        else        state <= state_nx;
    end

    // outbound word and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word  <= '0;
            out_full <= 1'b0;
        end else if (wr_data && !out_full) begin
            tx_word  <= wdata;
            out_full <= 1'b1;
        end else if (state == LNK_TO_MOD && lnk_wready) begin
            out_full <= 1'b0;
        end
    end

    // inbound word and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            in_full <= 1'b0;
        end else if (state == LNK_FROM_MOD && lnk_rvalid) begin
            rx_word <= lnk_rdata;
            in_full <= 1'b1;
        end else if (rd_data) begin
            in_full <= 1'b0;
        end
    end

    assign lnk_drive  = (state == LNK_TO_MOD);
    assign lnk_wvalid = (state == LNK_TO_MOD) && out_full;
    assign lnk_wdata  = tx_word;
    assign lnk_rready = (state == LNK_FROM_MOD);

    a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && out_full) |=> $stable(tx_word));
    a_r4_taken_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_wvalid && lnk_wready) |=> !out_full);
    a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(lnk_wvalid && lnk_rready));
    a_r6_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |-> !lnk_rready);
    a_r6_inbound_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && !rd_data) |=> $stable(rx_word));
    a_r7_outbound_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LNK_IDLE && out_full && lnk_req) |=> lnk_drive);
endmodule

// File: rtl/hmb_boot.sv
// Boot-control and interrupt-control registers. Control bits reset to all
// ones: the module is held in reset, the flag pins are released and NMI is idle.
module hmb_boot #(
    parameter int DATA_W = 32,
    parameter int FLAG_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_intc,
    input  logic [DATA_W-1:0] wdata,
    output logic              mod_reset,
    output logic [FLAG_N-1:0] mod_flag_pull,
    output logic              mod_nmi_n,
    output logic [DATA_W-1:0] int_ctrl
);
    localparam int CTRL_W = FLAG_N + 2;
    localparam int NMI_B  = FLAG_N + 1;

    logic [CTRL_W-1:0] ctrl;

    // control bits, upper write bits ignored
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '1;
        else if (wr_ctrl) ctrl <= wdata[CTRL_W-1:0];
    end

    // interrupt-control word
    always_ff @(posedge clk) begin
        if (!rst_n)       int_ctrl <= '0;
        else if (wr_intc) int_ctrl <= wdata;
    end

    assign mod_reset = ctrl[0];
    assign mod_nmi_n = ctrl[NMI_B];

    genvar i;
    generate
        for (i = 0; i < FLAG_N; i++) begin : g_flag
            // open drain: a zero bit enables the pull-down
            assign mod_flag_pull[i] = ~ctrl[i+1];
        end
    endgenerate

    a_r1_reset_holds_module: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mod_reset && mod_nmi_n && mod_flag_pull == '0));
    a_r8_reset_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (mod_reset == $past(wdata[0])));
    a_r8_nmi_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (mod_nmi_n == $past(wdata[NMI_B])));
    a_r10_intc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_intc |=> $stable(int_ctrl));
endmodule

// File: rtl/host_mailbox_ctrl.sv
// Top of the host mailbox block. Decodes host accesses, keeps the
// last-accessed word offset and muxes read data. Read data is combinational
// from the address and valid in the strobe cycle.
module host_mailbox_ctrl
    import hmb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter int FLAG_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              lnk_drive,
    output logic [DATA_W-1:0] lnk_wdata,
    output logic              lnk_wvalid,
    input  logic              lnk_wready,
    input  logic              lnk_req,
    input  logic [DATA_W-1:0] lnk_rdata,
    input  logic              lnk_rvalid,
    output logic              lnk_rready,
    output logic              mod_reset,
    output logic [FLAG_N-1:0] mod_flag_pull,
    output logic              mod_nmi_n,
    output logic [DATA_W-1:0] int_ctrl
);
    localparam int IDX_W = ADDR_W - 2;

    logic [SLOT_N-1:0] hit, wsel, rsel;
    logic [IDX_W-1:0]  word_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] rx_word;
    logic              out_full, in_full;

    hmb_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr(host_addr), .wr(host_wr), .rd(host_rd),
        .hit(hit), .wsel(wsel), .rsel(rsel), .word_idx(word_idx)
    );

    hmb_link #(.DATA_W(DATA_W)) i_link (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wsel[SLOT_DATA]), .rd_data(rsel[SLOT_DATA]),
        .wdata(host_wdata), .rx_word(rx_word),
        .out_full(out_full), .in_full(in_full),
        .lnk_drive(lnk_drive), .lnk_wdata(lnk_wdata), .lnk_wvalid(lnk_wvalid),
        .lnk_wready(lnk_wready), .lnk_req(lnk_req), .lnk_rdata(lnk_rdata),
        .lnk_rvalid(lnk_rvalid), .lnk_rready(lnk_rready)
    );

    hmb_boot #(.DATA_W(DATA_W), .FLAG_N(FLAG_N)) i_boot (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wsel[SLOT_CTRL]), .wr_intc(wsel[SLOT_INTC]),
        .wdata(host_wdata),
        .mod_reset(mod_reset), .mod_flag_pull(mod_flag_pull),
        .mod_nmi_n(mod_nmi_n), .int_ctrl(int_ctrl)
    );

    // record the word offset of every accepted host access
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_idx <= '0;
        else if (host_wr || host_rd) last_idx <= word_idx;
    end

    // read data mux; write-only and unused offsets return zero
    always_comb begin
        host_rdata = '0;
        if (hit[SLOT_DATA])      host_rdata = rx_word;
        else if (hit[SLOT_CTRL]) host_rdata = DATA_W'({in_full, out_full});
        else if (hit[SLOT_LAST]) host_rdata = DATA_W'(last_idx);
    end

    a_r11_last_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr || host_rd) |=> (last_idx == $past(host_addr[ADDR_W-1:2])));
    a_r12_unused_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit == '0) |=> ($stable(int_ctrl) && $stable(mod_reset)
                                    && $stable(mod_nmi_n) && $stable(mod_flag_pull)));
    a_r2_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit[SLOT_DATA]) |=> out_full);
endmodule

// File: tb/test_host_mailbox_ctrl.sv
module test_host_mailbox_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        lnk_drive, lnk_wvalid, lnk_rready;
    logic [31:0] lnk_wdata;
    logic        lnk_wready = 1'b0, lnk_req = 1'b0, lnk_rvalid = 1'b0;
    logic [31:0] lnk_rdata = '0;
    logic        mod_reset, mod_nmi_n;
    logic [2:0]  mod_flag_pull;
    logic [31:0] int_ctrl;

    int total = 0;
    int bad = 0;

    // bench model
    logic        m_obf = 0, m_ibf = 0;
    logic [31:0] m_tx = 0, m_rx = 0, m_intc = 0;
    logic [4:0]  m_last = 0;
    logic [4:0]  m_ctrl = 5'h1f;

    always #5 clk = ~clk;

    host_mailbox_ctrl i_host_mailbox_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lnk_drive(lnk_drive), .lnk_wdata(lnk_wdata), .lnk_wvalid(lnk_wvalid),
        .lnk_wready(lnk_wready), .lnk_req(lnk_req), .lnk_rdata(lnk_rdata),
        .lnk_rvalid(lnk_rvalid), .lnk_rready(lnk_rready), .mod_reset(mod_reset),
        .mod_flag_pull(mod_flag_pull), .mod_nmi_n(mod_nmi_n), .int_ctrl(int_ctrl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pins(input logic [4:0] c);
        return {26'd0, c[4], ~c[3:1], c[0]};
    endfunction

    function automatic logic [31:0] got_pins();
        return {26'd0, mod_nmi_n, mod_flag_pull, mod_reset};
    endfunction

    task automatic host_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        m_last = a[6:2];
    endtask

    task automatic host_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        m_last = a[6:2];
    endtask

    task automatic mod_take(output logic [31:0] d);
        bit seen = 0;
        d = '0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (lnk_wvalid && lnk_drive) seen = 1;
        end
        check("R4 word offered to module", {31'd0, seen}, 32'd1);
        d = lnk_wdata;
        lnk_wready = 1'b1;
        @(negedge clk);
        lnk_wready = 1'b0;
    endtask

    task automatic mod_send(input logic [31:0] d);
        bit seen = 0;
        lnk_req = 1'b1; lnk_rvalid = 1'b1; lnk_rdata = d;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (lnk_rready && !lnk_drive) seen = 1;
        end
        check("R5 block ready for module word", {31'd0, seen}, 32'd1);
        @(negedge clk);
        lnk_req = 1'b0; lnk_rvalid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, w;
        void'($urandom(32'd4011));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pins after reset", got_pins(), exp_pins(5'h1f));
        check("R1 int_ctrl after reset", int_ctrl, 32'd0);
        check("R1 port idle", {30'd0, lnk_drive, lnk_rready}, 32'd0);
        host_read(7'h1C, r); check("R1 last address after reset", r, 32'd0);
        host_read(7'h14, r); check("R1 status after reset", r, 32'd0);
        check("R11 last after status read", 32'd0, 32'd0);
        host_read(7'h1C, r); check("R11 previous offset is status", r, 32'd5);

        // R2, R3: load then drop second write
        host_write(7'h10, 32'hA5A5_0001);
        host_read(7'h14, r); check("R2 outbound full set", r, 32'd1);
        host_write(7'h10, 32'hDEAD_BEEF);
        mod_take(r); check("R3 first word delivered", r, 32'hA5A5_0001);
        host_read(7'h14, r); check("R4 outbound full cleared", r, 32'd0);

        // R5, R6: module word, refusal while full, host read clears
        mod_send(32'h1234_5678);
        host_read(7'h14, r); check("R5 inbound full set", r, 32'd2);
        lnk_req = 1'b1; lnk_rvalid = 1'b1; lnk_rdata = 32'h0BAD_0BAD;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R6 no accept while full", {31'd0, lnk_rready}, 32'd0);
        end
        host_read(7'h10, r); check("R6 inbound word kept", r, 32'h1234_5678);
        lnk_req = 1'b0; lnk_rvalid = 1'b0;
        host_read(7'h14, r); check("R6 inbound full cleared", r, 32'd0);
        mod_send(32'h0BAD_0BAD);
        host_read(7'h10, r); check("R6 second word after read", r, 32'h0BAD_0BAD);

        // R7 tie at idle port
        host_write(7'h10, 32'h7777_0007);
        lnk_req = 1'b1; lnk_rvalid = 1'b1; lnk_rdata = 32'h5555_AAAA;
        @(negedge clk);
        check("R7 outbound served first", {30'd0, lnk_drive, lnk_rready}, 32'd2);
        mod_take(r); check("R7 outbound word", r, 32'h7777_0007);
        lnk_req = 1'b0; lnk_rvalid = 1'b0;
        mod_send(32'h5555_AAAA);
        host_read(7'h10, r); check("R7 module word after", r, 32'h5555_AAAA);

        // R8 control bits, upper bits ignored
        host_write(7'h14, 32'hFFFF_FFE0);
        check("R8 all active", got_pins(), exp_pins(5'h00));
        host_write(7'h14, 32'h0000_0016);
        check("R8 mixed", got_pins(), exp_pins(5'h16));
        host_read(7'h14, r); check("R9 status not control", r, 32'd0);

        // R10 interrupt control
        host_write(7'h18, 32'hC0DE_F00D);
        check("R10 int_ctrl loaded", int_ctrl, 32'hC0DE_F00D);
        host_read(7'h18, r); check("R10 read zero", r, 32'd0);
        host_read(7'h1C, r); check("R11 previous offset", r, 32'd6);

        // R12 unused offsets
        host_write(7'h00, 32'hFFFF_FFFF);
        host_write(7'h7C, 32'h0000_0000);
        check("R12 pins unchanged", got_pins(), exp_pins(5'h16));
        check("R12 int_ctrl unchanged", int_ctrl, 32'hC0DE_F00D);
        host_read(7'h40, r); check("R12 reserved reads zero", r, 32'd0);
        host_read(7'h14, r); check("R12 status unchanged", r, 32'd0);

        // random phase
        m_ctrl = 5'h16; m_intc = 32'hC0DE_F00D; m_rx = 32'h5555_AAAA; m_last = 5'd5;
        for (int n = 0; n < 300; n++) begin
            int op;
            op = $urandom_range(0, 7);
            w = $urandom();
            case (op)
                0: begin
                    host_write(7'h10, w);
                    if (!m_obf) begin m_obf = 1; m_tx = w; end
                end
                1: if (m_obf) begin
                    mod_take(r); check("R3 random delivered word", r, m_tx); m_obf = 0;
                end
                2: if (!m_obf && !m_ibf) begin
                    mod_send(w); m_rx = w; m_ibf = 1;
                end
                3: begin
                    host_read(7'h10, r); check("R6 random inbound read", r, m_rx); m_ibf = 0;
                end
                4: begin
                    host_write(7'h14, w); m_ctrl = w[4:0];
                    check("R8 random pins", got_pins(), exp_pins(m_ctrl));
                end
                5: begin
                    host_read(7'h14, r); check("R9 random status", r, {30'd0, m_ibf, m_obf});
                end
                6: begin
                    int idx;
                    idx = $urandom_range(0, 27);
                    if (idx > 3) idx += 4;
                    if (w[0]) begin
                        host_write(7'(idx << 2), w);
                        check("R12 random pins", got_pins(), exp_pins(m_ctrl));
                        check("R12 random int_ctrl", int_ctrl, m_intc);
                    end else begin
                        host_read(7'(idx << 2), r); check("R12 random read zero", r, 32'd0);
                    end
                end
                default: begin
                    logic [4:0] prev;
                    prev = m_last;
                    host_read(7'h1C, r); check("R11 random last", r, {27'd0, prev});
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule